// File: doc/BRIEF.md
# Seven-Level Symmetric Switching Sequence Generator

This block turns one sample request into the full switching pattern of a seven-level, three-phase neutral-point-clamped inverter for one sample period. A request carries a sector code, a region code and three dwell counts. The block then visits four inverter states in order during the first half of the period. During the second half it visits the same four states backwards. Between any two neighbouring states, only one phase moves, and it moves by one level.

For each phase the block presents the current level (0 to 6) and the gate word for that phase's twelve-switch leg. The sample-period controller that computes the dwell counts sits upstream. Dead-time insertion sits downstream. A request that arrives while a period is running is held and starts at the exact edge where the running period ends.

Top module: `seq7_gen`

## Requirements
- R1: While reset is low, and after reset until the first accepted request, every phase level is 0 and every gate word is 12'h03F.
- R2: A strobe is accepted only when the sector code equals 1 and the region code lies in 26..36. If the block is idle, an accepted strobe starts a period at the next rising edge, and the first state is visible from that edge.
- R3: With j = (region-26)/2, the four states (phase a, b, c) are: state0 = (5, j, 0); state1 = (5, j+1, 0) for an odd region offset and (6, j, 0) for an even offset; state2 = (6, j+1, 0); state3 = (6, j+1, 1).
- R4: The period runs eight steps. Steps 0..3 show states 0..3, and steps 4..7 show states 3, 2, 1, 0.
- R5: A step that shows state0 or state3 lasts floor(T0/4) cycles. A step that shows state1 lasts floor(T1/2) cycles, and a step that shows state2 lasts floor(T2/2) cycles. A computed length of zero lasts one cycle.
- R6: Between consecutive cycles inside a period, the sum over the phases of the absolute level change is at most 1.
- R7: Gate bit i of a phase word (bit 0 = first switch of the leg) is on exactly when level ≤ i ≤ level+5, so exactly six bits are on.
- R8: A request accepted during a running period is held and starts at the edge where step 7 ends. A later request replaces an earlier held one.
- R9: A strobe with any other sector or region code has no effect. Levels hold, and a running period finishes unchanged.
- R10: When a period ends and no request is held, the outputs keep state0 of that period until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | One-cycle sample request |
| sector | input | 3 | Sector code |
| region | input | 7 | Region code within the sector |
| t0_cnt | input | CW | Zero-vector dwell count for the period |
| t1_cnt | input | CW | Dwell count of the first middle state |
| t2_cnt | input | CW | Dwell count of the second middle state |
| lvl_a | output | 3 | Phase a level |
| lvl_b | output | 3 | Phase b level |
| lvl_c | output | 3 | Phase c level |
| gate_a | output | 12 | Phase a gate word |
| gate_b | output | 12 | Phase b gate word |
| gate_c | output | 12 | Phase c gate word |

## Verification
The bench builds the block with CW = 8. This keeps every dwell count small enough that a full-scale request of 255 still finishes in a few hundred cycles, which brings the largest step lengths within reach next to the zero-length steps. Random and directed periods cover all eleven regions. Requests are also placed mid-period, so that the held start, its replacement and rejected codes are all seen at the sequence boundary.

// File: rtl/seq7_gen.sv
module seq7_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [2:0]    sector,
  input  logic [6:0]    region,
  input  logic [CW-1:0] t0_cnt,
  input  logic [CW-1:0] t1_cnt,
  input  logic [CW-1:0] t2_cnt,
  output logic [2:0]    lvl_a,
  output logic [2:0]    lvl_b,
  output logic [2:0]    lvl_c,
  output logic [11:0]   gate_a,
  output logic [11:0]   gate_b,
  output logic [11:0]   gate_c
);
  localparam logic [6:0]    REG_LO = 7'd26;
  localparam logic [6:0]    REG_HI = 7'd36;
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};

  function automatic logic [8:0] state_of(logic [1:0] idx, logic [2:0] j, logic odd);
    logic [2:0] a, b, c;
    a = 3'd5; b = j; c = 3'd0;
    case (idx)
      2'd1: if (odd) b = j + 3'd1; else a = 3'd6;
      2'd2: begin a = 3'd6; b = j + 3'd1; end
      2'd3: begin a = 3'd6; b = j + 3'd1; c = 3'd1; end
      default: ;
    endcase
    return {a, b, c};
  endfunction

  function automatic logic [CW-1:0] load_of(logic [CW-1:0] d);
    return (d == '0) ? '0 : d - ONE;
  endfunction

  function automatic logic [CW-1:0] dw(logic [1:0] idx, logic [CW-1:0] d0,
                                       logic [CW-1:0] d1, logic [CW-1:0] d2);
    case (idx)
      2'd1:    return d1;
      2'd2:    return d2;
      default: return d0;
    endcase
  endfunction

  function automatic logic [11:0] gate_of(logic [2:0] l);
    logic [11:0] g;
    for (int i = 0; i < 12; i++) g[i] = (i >= int'(l)) && (i <= int'(l) + 5);
    return g;
  endfunction

  logic          active, odd, pend, p_odd;
  logic [2:0]    step, j, p_j;
  logic [CW-1:0] cnt, q0, q1, q2, p_q0, p_q1, p_q2;

  wire [6:0]    roff  = region - REG_LO;
  wire          valid = strobe && (sector == 3'd1) && (region >= REG_LO) && (region <= REG_HI);
  wire [2:0]    s_j   = roff[3:1];
  wire          s_odd = roff[0];
  wire [CW-1:0] s_q0  = t0_cnt >> 2;
  wire [CW-1:0] s_q1  = t1_cnt >> 1;
  wire [CW-1:0] s_q2  = t2_cnt >> 1;

  wire [2:0] nstep = step + 3'd1;
  wire [1:0] nidx  = nstep[2] ? ~nstep[1:0] : nstep[1:0];
  wire       fin   = active && (cnt == '0) && (step == 3'd7);
  wire       open_slot = !active || fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; p_j <= '0; p_odd <= 1'b0;
      p_q0 <= '0; p_q1 <= '0; p_q2 <= '0;
    end else begin
      pend <= open_slot ? (pend && valid) : (pend || valid);
      if (valid) begin
        p_j <= s_j; p_odd <= s_odd;
        p_q0 <= s_q0; p_q1 <= s_q1; p_q2 <= s_q2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; step <= '0; cnt <= '0;
      j <= '0; odd <= 1'b0; q0 <= '0; q1 <= '0; q2 <= '0;
      {lvl_a, lvl_b, lvl_c} <= '0;
    end else if (open_slot) begin
      if (pend) begin
        active <= 1'b1; step <= '0;
        j <= p_j; odd <= p_odd; q0 <= p_q0; q1 <= p_q1; q2 <= p_q2;
        cnt <= load_of(p_q0);
        {lvl_a, lvl_b, lvl_c} <= state_of(2'd0, p_j, p_odd);
      end else if (valid) begin
        active <= 1'b1; step <= '0;
        j <= s_j; odd <= s_odd; q0 <= s_q0; q1 <= s_q1; q2 <= s_q2;
        cnt <= load_of(s_q0);
        {lvl_a, lvl_b, lvl_c} <= state_of(2'd0, s_j, s_odd);
      end else begin
        active <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end else begin
      step <= nstep;
      cnt  <= load_of(dw(nidx, q0, q1, q2));
      {lvl_a, lvl_b, lvl_c} <= state_of(nidx, j, odd);
    end
  end

  assign gate_a = gate_of(lvl_a);
  assign gate_b = gate_of(lvl_b);
  assign gate_c = gate_of(lvl_c);
endmodule

module seq7_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic [2:0]  step,
  input logic [2:0]  lvl_a,
  input logic [2:0]  lvl_b,
  input logic [2:0]  lvl_c,
  input logic [11:0] gate_a,
  input logic [11:0] gate_b,
  input logic [11:0] gate_c
);
  function automatic int ad(logic [2:0] x, logic [2:0] y);
    return (x > y) ? int'(x - y) : int'(y - x);
  endfunction

  a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && step != 3'd0) |->
    (ad(lvl_a, $past(lvl_a)) + ad(lvl_b, $past(lvl_b)) + ad(lvl_c, $past(lvl_c)) <= 1));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(!active)) |-> ($stable(lvl_a) && $stable(lvl_b) && $stable(lvl_c)));

  a_r7_six_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gate_a) == 6) && ($countones(gate_b) == 6) && ($countones(gate_c) == 6));

  a_r7_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    gate_a[lvl_a] && gate_b[lvl_b] && gate_c[lvl_c]);

  a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a <= 3'd6) && (lvl_b <= 3'd6) && (lvl_c <= 3'd6));
endmodule

bind seq7_gen seq7_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .step(step),
  .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
  .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
);

// File: tb/test_seq7_gen.sv
module test_seq7_gen;
  localparam int CLK_NS = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [2:0] sector = '0;
  logic [6:0] region = '0;
  logic [CW-1:0] t0 = '0, t1 = '0, t2 = '0;
  logic [2:0] lvl_a, lvl_b, lvl_c;
  logic [11:0] gate_a, gate_b, gate_c;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  seq7_gen #(.CW(CW)) i_seq7_gen (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sector(sector), .region(region),
    .t0_cnt(t0), .t1_cnt(t1), .t2_cnt(t2),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c));

  function automatic logic [8:0] exp_state(int idx, int reg_code);
    int jj = (reg_code - 26) / 2;
    int od = (reg_code - 26) % 2;
    int a = 5, b = jj, c = 0;
    if (idx == 1) begin if (od == 1) b = jj + 1; else a = 6; end
    if (idx >= 2) begin a = 6; b = jj + 1; end
    if (idx == 3) c = 1;
    return {a[2:0], b[2:0], c[2:0]};
  endfunction

  function automatic int step_len(int idx, int a0, int a1, int a2);
    int n = (idx == 1) ? a1 / 2 : (idx == 2) ? a2 / 2 : a0 / 4;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [11:0] exp_gate(logic [2:0] l);
    return 12'h03F << l;
  endfunction

  task automatic chk(string tag, logic [8:0] e);
    checks++;
    if ({lvl_a, lvl_b, lvl_c} !== e) begin
      errors++;
      $display("FAIL %s levels got %0d%0d%0d expected %0d%0d%0d", tag,
               lvl_a, lvl_b, lvl_c, e[8:6], e[5:3], e[2:0]);
    end else if ({gate_a, gate_b, gate_c} !== {exp_gate(e[8:6]), exp_gate(e[5:3]), exp_gate(e[2:0])}) begin
      errors++;
      $display("FAIL R7 gates got %h %h %h expected %h %h %h", gate_a, gate_b, gate_c,
               exp_gate(e[8:6]), exp_gate(e[5:3]), exp_gate(e[2:0]));
    end
  endtask

  task automatic pulse(int sec, int rg, int a0, int a1, int a2);
    sector = sec[2:0]; region = rg[6:0];
    t0 = a0[CW-1:0]; t1 = a1[CW-1:0]; t2 = a2[CW-1:0];
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic expect_period(int rg, int a0, int a1, int a2, string tag);
    for (int s = 0; s < 8; s++) begin
      int idx = (s < 4) ? s : 7 - s;
      int len = step_len(idx, a0, a1, a2);
      for (int k = 0; k < len; k++) begin
        chk((s == 0 && k == 0) ? "R2 launch" : (s >= 4 ? {tag, " R4"} : tag), exp_state(idx, rg));
        @(negedge clk);
      end
    end
  endtask

  task automatic hold(int n, logic [8:0] e, string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, e);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    hold(2, 9'd0, "R1 after reset");

    pulse(1, 26, 8, 4, 6);
    expect_period(26, 8, 4, 6, "R3 r26");
    hold(3, exp_state(0, 26), "R10 idle");

    pulse(1, 36, 12, 10, 2);
    expect_period(36, 12, 10, 2, "R3 r36");

    pulse(1, 27, 3, 1, 0);
    expect_period(27, 3, 1, 0, "R5 zero dwell");
    hold(2, exp_state(0, 27), "R10 idle");

    pulse(1, 31, 255, 255, 255);
    expect_period(31, 255, 255, 255, "R5 max dwell");

    pulse(2, 30, 8, 8, 8);
    hold(3, exp_state(0, 31), "R9 bad sector");
    pulse(1, 25, 8, 8, 8);
    hold(3, exp_state(0, 31), "R9 region low");
    pulse(1, 37, 8, 8, 8);
    hold(3, exp_state(0, 31), "R9 region high");

    pulse(1, 28, 9, 7, 5);
    fork begin repeat (2) @(negedge clk); pulse(1, 33, 6, 4, 8); end join_none
    expect_period(28, 9, 7, 5, "R8 first");
    expect_period(33, 6, 4, 8, "R8 held start");
    hold(2, exp_state(0, 33), "R10 idle");

    pulse(1, 30, 10, 6, 6);
    fork begin
      repeat (2) @(negedge clk); pulse(1, 32, 4, 4, 4);
      pulse(1, 35, 5, 9, 3);
    end join_none
    expect_period(30, 10, 6, 6, "R8 first");
    expect_period(35, 5, 9, 3, "R8 replaced");

    pulse(1, 29, 8, 8, 8);
    fork begin repeat (2) @(negedge clk); pulse(4, 29, 20, 20, 20); end join_none
    expect_period(29, 8, 8, 8, "R9 mid-period");
    hold(3, exp_state(0, 29), "R9 no restart");

    for (int n = 0; n < 40; n++) begin
      int rg = 26 + int'($urandom % 11);
      int a0 = int'($urandom % 40), a1 = int'($urandom % 40), a2 = int'($urandom % 40);
      pulse(1, rg, a0, a1, a2);
      expect_period(rg, a0, a1, a2, "R3 random R6");
      if ($urandom % 3 == 0) begin
        pulse(int'($urandom % 8) == 1 ? 0 : int'($urandom % 8), 40, a0, a1, a2);
        hold(2, exp_state(0, rg), "R9 random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule